// File: doc/BRIEF.md
# Clickless Mute and Soft-Start Sequencer

This block is the output-level controller of a stereo audio conversion path. After reset it holds the path at ground. Once the clock monitor reports a valid clock, it raises a DC offset code slowly from zero to the quiescent bias level. It then clears the sample registers and ramps a signal gain from zero to unity, one step per sample period, so that audio fades in without a click. A two-channel multiplier applies the gain to the incoming samples.

Loss of clock is handled in one of two ways. If the bias ramp is still running, the offset code freezes where it is and resumes when the clock recovers. Once the bias has reached quiescent, a fault mutes the audio at once while the offset stays at quiescent. Recovery from a mute restarts only the gain ramp. The bias ramp is not repeated.

Top module: `clickless_ramp_seq`

## Requirements
- R1: After reset, `seqState` is 0 (ground), `offsetCode` is 0, `gainCode` is 0 and both outputs are 0. These values hold until the first cycle in which no loss event is present.
- R2: In the bias-ramp state (`seqState`=1), with no loss event, `offsetCode` rises by exactly 1 every `DC_DIV` clock cycles until it equals `QUIESCENT`. In the following cycle the state becomes 3 (init).
- R3: A loss event during the bias ramp moves the state to 2 (bias hold). While in hold, `offsetCode` does not change. The first cycle without a loss event returns the state to 1 and the ramp continues from the held value.
- R4: The init state (3) lasts one cycle. It clears both sample outputs and the gain to 0, then enters soft-start (4), or enters mute (6) if a loss event is present.
- R5: In soft-start, `gainCode` increases by 1 on each `sampleTick`, up to full scale `2**GAIN_W`. In the cycle after the gain reaches full scale with no loss event, the state becomes 5 (normal).
- R6: A loss event seen in soft-start or normal takes the state to 6 (mute) at the next clock edge. In that same cycle, `gainCode` and both sample outputs become 0.
- R7: A loss event is any cycle in which `clkValid` is low or any of `ratioFault`, `mclkTimeout`, `serialModeSwitch` or `lrClockLoss` is high. Each of these inputs, on its own, is enough to cause a loss event.
- R8: In mute, `offsetCode` stays at `QUIESCENT` and `gainCode` stays at 0. The first cycle without a loss event returns the state to 4, and the gain ramp starts again from 0.
- R9: In soft-start and normal, each `sampleTick` without a loss event loads each output with (input × `gainCode`) arithmetically shifted right by `GAIN_W`, keeping the low `SAMP_W` bits. Between ticks the outputs hold their value. In normal, each output equals its input exactly.
- R10: `seqState` uses this encoding: 0 ground, 1 bias ramp, 2 bias hold, 3 init, 4 soft-start, 5 normal, 6 mute. The value 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkValid | input | 1 | Clock monitor reports a valid clock ratio |
| ratioFault | input | 1 | Strobe: ratio invalid or changed |
| mclkTimeout | input | 1 | Strobe: master clock too slow or missing |
| serialModeSwitch | input | 1 | Strobe: serial clock changed between internal and external source |
| lrClockLoss | input | 1 | Strobe: frame clock lost |
| sampleTick | input | 1 | One-cycle pulse per audio sample period |
| leftIn | input | SAMP_W | Left sample, two's complement |
| rightIn | input | SAMP_W | Right sample, two's complement |
| offsetCode | output | OFF_W | DC bias code, 0 = ground |
| gainCode | output | GAIN_W+1 | Signal gain, 2**GAIN_W = unity |
| leftOut | output | SAMP_W | Gain-scaled left sample |
| rightOut | output | SAMP_W | Gain-scaled right sample |
| seqState | output | 3 | Sequencer state code |

## Verification
The hardest conditions to reach are faults in the late part of the sequence. A fault during the bias ramp must freeze the offset part-way. A fault in soft-start must cut the gain at a middle value. A fault may also arrive exactly on a sample tick. To reach these, the bench uses a small quiescent level, a short prescale and a 4-bit gain. It places each fault strobe at a fixed cycle count after the clock becomes valid, and it keeps the sample ticks running, so faults fall mid-ramp, on ticks and between ticks. A behavioural model runs in parallel and is compared on every clock. It follows the same sequence: each fault source on its own, the re-entry into soft-start from mute, and full-scale positive and negative samples.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

  typedef enum logic [2:0] {
    ST_GROUND    = 3'd0,
    ST_DC_RAMP   = 3'd1,
    ST_DC_HOLD   = 3'd2,
    ST_INIT      = 3'd3,
    ST_SOFTSTART = 3'd4,
    ST_NORMAL    = 3'd5,
    ST_MUTED     = 3'd6
  } seqState_e;

  // strobes from the sequencer to the level datapath
  typedef struct packed {
    logic offRun;    // bias prescaler/offset may advance
    logic gainInc;   // advance gain one step
    logic gainClr;   // force gain to zero
    logic sampLoad;  // capture scaled samples
    logic sampClr;   // force samples to zero
  } rampCmd_t;

endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clkValid,
  input  logic      ratioFault,
  input  logic      mclkTimeout,
  input  logic      serialModeSwitch,
  input  logic      lrClockLoss,
  input  logic      sampleTick,
  input  logic      offAtQuiescent,
  input  logic      gainAtFull,
  output rampCmd_t  cmd,
  output seqState_e state
);

  logic      lossEvent;
  seqState_e nextState;
  logic      audible;

  // R7: any single source is enough
  assign lossEvent = !clkValid | ratioFault | mclkTimeout | serialModeSwitch | lrClockLoss;
  assign audible   = (state == ST_SOFTSTART) || (state == ST_NORMAL);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_GROUND:    if (!lossEvent) nextState = ST_DC_RAMP;
      ST_DC_RAMP: begin
        if (lossEvent)           nextState = ST_DC_HOLD;
        else if (offAtQuiescent) nextState = ST_INIT;
      end
      ST_DC_HOLD:   if (!lossEvent) nextState = ST_DC_RAMP;
      ST_INIT:      nextState = lossEvent ? ST_MUTED : ST_SOFTSTART;
      ST_SOFTSTART: begin
        if (lossEvent)       nextState = ST_MUTED;
        else if (gainAtFull) nextState = ST_NORMAL;
      end
      ST_NORMAL:    if (lossEvent) nextState = ST_MUTED;
      ST_MUTED:     if (!lossEvent) nextState = ST_SOFTSTART;
      default:      nextState = ST_GROUND;
    endcase
  end

  always_comb begin
    cmd          = '0;
    cmd.offRun   = (state == ST_DC_RAMP) && !lossEvent && !offAtQuiescent;
    cmd.gainInc  = (state == ST_SOFTSTART) && !lossEvent && sampleTick && !gainAtFull;
    cmd.sampLoad = audible && !lossEvent && sampleTick;
    cmd.gainClr  = (state == ST_INIT) || (audible && lossEvent);
    cmd.sampClr  = cmd.gainClr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_GROUND;
    else        state <= nextState;
  end

  p_state_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state != 3'd7);
  p_init_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_INIT |=> (state == ST_SOFTSTART || state == ST_MUTED));
  p_mute_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTED && !lossEvent) |=> state == ST_SOFTSTART);
  p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DC_RAMP && lossEvent) |=> state == ST_DC_HOLD);

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_seq_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int QUIESCENT = 1966,
  parameter int DC_DIV    = 3000,
  parameter int GAIN_W    = 10,
  parameter int SAMP_W    = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rampCmd_t            cmd,
  input  logic [SAMP_W-1:0]   sampIn  [2],
  output logic [SAMP_W-1:0]   sampOut [2],
  output logic [OFF_W-1:0]    offsetCode,
  output logic [GAIN_W:0]     gainCode,
  output logic                offAtQuiescent,
  output logic                gainAtFull
);

  localparam int PRE_W  = (DC_DIV > 1) ? $clog2(DC_DIV) : 1;
  localparam int PROD_W = SAMP_W + GAIN_W + 2;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(DC_DIV - 1);
  localparam logic [OFF_W-1:0]  OFF_TOP   = OFF_W'(QUIESCENT);
  localparam logic [GAIN_W:0]   GAIN_UNIT = (GAIN_W+1)'(1) << GAIN_W;

  logic [PRE_W-1:0] preCnt;

  assign offAtQuiescent = (offsetCode == OFF_TOP);
  assign gainAtFull     = (gainCode == GAIN_UNIT);

  // bias ramp: one code per DC_DIV cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt     <= '0;
      offsetCode <= '0;
    end else if (!cmd.offRun) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt     <= '0;
      offsetCode <= offsetCode + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gainCode <= '0;
    else if (cmd.gainClr) gainCode <= '0;
    else if (cmd.gainInc) gainCode <= gainCode + 1'b1;
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    assign prod   = $signed(sampIn[ch]) * $signed({1'b0, gainCode});
    assign scaled = prod >>> GAIN_W;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            sampOut[ch] <= '0;
      else if (cmd.sampClr)  sampOut[ch] <= '0;
      else if (cmd.sampLoad) sampOut[ch] <= scaled[SAMP_W-1:0];
    end
    p_hold_between_ticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd.sampLoad && !cmd.sampClr) |=> $stable(sampOut[ch]));
  end

  p_offset_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    offsetCode <= OFF_TOP);
  p_offset_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.offRun |=> $stable(offsetCode));
  p_gain_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gainCode <= GAIN_UNIT);
  p_gain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.gainClr && !cmd.gainInc) |=> $stable(gainCode));

endmodule

// File: rtl/clickless_ramp_seq.sv
module clickless_ramp_seq
  import ramp_seq_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int QUIESCENT = 1966,
  parameter int DC_DIV    = 3000,
  parameter int GAIN_W    = 10,
  parameter int SAMP_W    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkValid,
  input  logic              ratioFault,
  input  logic              mclkTimeout,
  input  logic              serialModeSwitch,
  input  logic              lrClockLoss,
  input  logic              sampleTick,
  input  logic [SAMP_W-1:0] leftIn,
  input  logic [SAMP_W-1:0] rightIn,
  output logic [OFF_W-1:0]  offsetCode,
  output logic [GAIN_W:0]   gainCode,
  output logic [SAMP_W-1:0] leftOut,
  output logic [SAMP_W-1:0] rightOut,
  output logic [2:0]        seqState
);

  rampCmd_t          cmd;
  seqState_e         state;
  logic              offAtQuiescent;
  logic              gainAtFull;
  logic [SAMP_W-1:0] sampIn  [2];
  logic [SAMP_W-1:0] sampOut [2];
  logic              anyLoss;

  assign sampIn[0] = leftIn;
  assign sampIn[1] = rightIn;
  assign leftOut   = sampOut[0];
  assign rightOut  = sampOut[1];
  assign seqState  = state;
  assign anyLoss   = !clkValid | ratioFault | mclkTimeout | serialModeSwitch | lrClockLoss;

  ramp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clkValid(clkValid), .ratioFault(ratioFault),
    .mclkTimeout(mclkTimeout), .serialModeSwitch(serialModeSwitch),
    .lrClockLoss(lrClockLoss), .sampleTick(sampleTick),
    .offAtQuiescent(offAtQuiescent), .gainAtFull(gainAtFull),
    .cmd(cmd), .state(state)
  );

  ramp_datapath #(
    .OFF_W(OFF_W), .QUIESCENT(QUIESCENT), .DC_DIV(DC_DIV),
    .GAIN_W(GAIN_W), .SAMP_W(SAMP_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .sampIn(sampIn), .sampOut(sampOut),
    .offsetCode(offsetCode), .gainCode(gainCode),
    .offAtQuiescent(offAtQuiescent), .gainAtFull(gainAtFull)
  );

  p_ground_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GROUND |-> (offsetCode == '0 && gainCode == '0 && leftOut == '0 && rightOut == '0));
  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DC_HOLD |=> $stable(offsetCode));
  p_snap_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SOFTSTART || state == ST_NORMAL) && anyLoss)
      |=> (state == ST_MUTED && gainCode == '0 && leftOut == '0 && rightOut == '0));
  p_mute_bias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_MUTED |-> (offsetCode == OFF_W'(QUIESCENT) && gainCode == '0));

endmodule

// File: tb/tb_clickless_ramp_seq.sv
module tb_clickless_ramp_seq;

  localparam int OW = 6, Q = 10, DIV = 3, GW = 4, SW = 24;
  localparam int FULL = 1 << GW;

  logic clk = 0, rst_n = 0;
  logic clkValid = 0, ratioFault = 0, mclkTimeout = 0, serialModeSwitch = 0, lrClockLoss = 0;
  logic sampleTick = 0, tickEn = 0;
  logic [SW-1:0] leftIn = '0, rightIn = '0;
  logic [OW-1:0] offsetCode;
  logic [GW:0]   gainCode;
  logic [SW-1:0] leftOut, rightOut;
  logic [2:0]    seqState;

  int checks = 0, errors = 0, cyc = 0, tickCnt = 0, sampIdx = 0;
  bit done = 0;

  // reference model state
  int mSt = 0, mOff = 0, mPre = 0, mGain = 0;
  logic [SW-1:0] mL = '0, mR = '0;

  always #4 clk = ~clk;

  clickless_ramp_seq #(.OFF_W(OW), .QUIESCENT(Q), .DC_DIV(DIV), .GAIN_W(GW), .SAMP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .clkValid(clkValid), .ratioFault(ratioFault),
    .mclkTimeout(mclkTimeout), .serialModeSwitch(serialModeSwitch), .lrClockLoss(lrClockLoss),
    .sampleTick(sampleTick), .leftIn(leftIn), .rightIn(rightIn),
    .offsetCode(offsetCode), .gainCode(gainCode), .leftOut(leftOut), .rightOut(rightOut),
    .seqState(seqState));

  function automatic logic [SW-1:0] scale(logic [SW-1:0] s, int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    p = p >>> GW;
    return p[SW-1:0];
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // R7 loss combination, R2..R9 sequence, written from the requirements
  always @(posedge clk) begin
    bit loss;
    if (!rst_n) begin
      mSt = 0; mOff = 0; mPre = 0; mGain = 0; mL = '0; mR = '0;
    end else begin
      loss = !clkValid || ratioFault || mclkTimeout || serialModeSwitch || lrClockLoss;
      case (mSt)
        0: if (!loss) mSt = 1;
        1: if (loss) begin mSt = 2; mPre = 0; end
           else if (mOff == Q) begin mSt = 3; mPre = 0; end
           else if (mPre == DIV - 1) begin mPre = 0; mOff++; end
           else mPre++;
        2: if (!loss) mSt = 1;
        3: begin mL = '0; mR = '0; mGain = 0; mSt = loss ? 6 : 4; end
        4, 5: if (loss) begin mSt = 6; mGain = 0; mL = '0; mR = '0; end
              else begin
                if (sampleTick) begin mL = scale(leftIn, mGain); mR = scale(rightIn, mGain); end
                if (mSt == 4) begin
                  if (mGain == FULL) mSt = 5;
                  else if (sampleTick) mGain++;
                end
              end
        6: if (!loss) mSt = 4;
        default: mSt = 0;
      endcase
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10", "state", seqState, mSt);
      check("R2", "offsetCode", offsetCode, mOff);
      check("R5", "gainCode", gainCode, mGain);
      check("R9", "leftOut", leftOut, mL);
      check("R9", "rightOut", rightOut, mR);
    end
  end

  // sample tick every third cycle with varied data including extremes
  always @(negedge clk) begin
    sampleTick <= 0;
    if (tickEn) begin
      tickCnt <= (tickCnt == 2) ? 0 : tickCnt + 1;
      if (tickCnt == 2) begin
        sampleTick <= 1;
        sampIdx <= sampIdx + 1;
        case (sampIdx % 5)
          0: begin leftIn <= 24'h7FFFFF; rightIn <= 24'h800000; end
          1: begin leftIn <= 24'h800000; rightIn <= 24'h7FFFFF; end
          2: begin leftIn <= 24'hFFFFFF; rightIn <= 24'h000001; end
          default: begin leftIn <= SW'($urandom); rightIn <= SW'($urandom); end
        endcase
      end
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_state(int s, int limit);
    for (int i = 0; i < limit && seqState != s; i++) @(negedge clk);
  endtask

  task automatic pulse(int which);
    case (which)
      0: ratioFault = 1; 1: mclkTimeout = 1; 2: serialModeSwitch = 1; default: lrClockLoss = 1;
    endcase
    @(negedge clk);
    ratioFault = 0; mclkTimeout = 0; serialModeSwitch = 0; lrClockLoss = 0;
  endtask

  initial begin
    logic [OW-1:0] held;
    wait_cyc(3);
    check("R1", "reset state", seqState, 0);
    check("R1", "reset offset", offsetCode, 0);
    rst_n = 1;
    tickEn = 1;
    wait_cyc(6);
    check("R1", "ground while invalid", seqState, 0);
    check("R1", "gain while invalid", gainCode, 0);
    clkValid = 1;
    wait_cyc(10);
    check("R2", "ramping", seqState, 1);
    pulse(0);                               // R7 ratio fault alone
    check("R3", "hold after ratio fault", seqState, 2);
    held = offsetCode;
    clkValid = 0;
    wait_cyc(5);
    check("R3", "offset frozen", offsetCode, held);
    clkValid = 1;
    wait_cyc(4);
    pulse(1);                               // R7 master clock timeout alone
    check("R3", "hold after timeout", seqState, 2);
    wait_cyc(2);
    wait_state(3, 200);
    check("R4", "init reached", seqState, 3);
    @(negedge clk);
    check("R4", "soft-start after init", seqState, 4);
    check("R4", "samples cleared", leftOut, 0);
    wait_cyc(20);
    pulse(2);                               // R7 mode switch alone, mid soft-start
    check("R6", "muted", seqState, 6);
    check("R6", "gain cut", gainCode, 0);
    clkValid = 0;
    wait_cyc(4);
    check("R8", "offset kept at quiescent", offsetCode, Q);
    clkValid = 1;
    wait_cyc(2);
    check("R8", "restart soft-start", seqState, 4);
    wait_state(5, 400);
    check("R5", "normal reached", seqState, 5);
    check("R5", "gain full", gainCode, FULL);
    wait_cyc(15);
    pulse(3);                               // R7 frame clock loss alone, in normal
    check("R6", "mute from normal", seqState, 6);
    wait_cyc(3);
    wait_state(5, 400);
    wait_cyc(10);
    clkValid = 0;                           // R7 valid flag alone
    wait_cyc(2);
    check("R6", "mute on invalid", seqState, 6);
    clkValid = 1;
    wait_cyc(30);
    done = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (done || cyc > 20000) begin
      if (!done) begin
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=finished", cyc);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule